// File: doc/BRIEF.md
# Oscillator Startup Delay Timer

This block decides when the output of a main oscillator can be trusted. Software starts the oscillator by writing a control word that carries both an enable bit and an 8-bit startup count. The write drops the stable flag at once. The block then counts down from the written value. The count advances once for every eight periods of a slow reference clock. When the count is used up, the flag rises to mark the main clock as valid. A level interrupt follows the flag whenever its mask bit is set.

A bypass setting covers the case where an external clock drives the oscillator input directly. Writing the bypass bit with the enable bit clear marks the clock valid without any countdown. Clearing the enable bit with bypass clear drops the flag on the next cycle and abandons any countdown in progress.

The slow reference arrives as a one-cycle enable pulse, `slow_ce`, in the system clock domain. Register access is a plain write strobe with an address, plus a combinational read port. This block has no streaming data path, so no valid/ready handshake and no back-pressure rules apply.

Top module: `osc_startup_timer`

## Requirements
- R1: After reset, `osc_stable`, `irq`, the control readback (address 0) and the mask readback (address 2) are all zero.
- R2: A write to address 0 with bit 0 (enable) set loads bits [15:8] as the startup count and clears `osc_stable` on the next cycle, even if it was set.
- R3: For a startup count N of 1 or more, `osc_stable` rises after exactly 8·N `slow_ce` pulses counted from the start write, and not before. Once set, it stays set until the next write to address 0.
- R4: A startup count of 0 sets `osc_stable` after exactly 8 `slow_ce` pulses.
- R5: The largest count, 255, sets `osc_stable` after exactly 2040 pulses.
- R6: A write to address 0 with bit 0 clear and bit 1 (bypass) clear clears `osc_stable` on the next cycle. It also stops the countdown, so later `slow_ce` pulses do not set the flag.
- R7: A write to address 0 with bit 0 clear and bit 1 set sets `osc_stable` on the next cycle, with no countdown.
- R8: A start write made while a countdown is running reloads the count and restarts the divide-by-eight phase. The flag then rises 8·N pulses after the second write.
- R9: `irq` is high exactly when `osc_stable` is high and mask bit 0 (address 2) is set.
- R10: Address 0 reads back the last control word: bit 0 enable, bit 1 bypass, bits [15:8] count, all other bits 0. Address 1 bit 0 reads `osc_stable`. Address 3 reads zero.
- R11: When bit 0 and bit 1 are both set, the enable bit wins: the flag is cleared and the full countdown runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_ce | input | 1 | One-cycle pulse per slow reference clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 2 mask) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| osc_stable | output | 1 | Main clock valid flag |
| irq | output | 1 | Level interrupt: flag gated by mask |

## Verification
The assertions check the following on every cycle:
- each kind of control write (start, disable, bypass) has its effect on the flag one cycle later;
- the flag never drops without a control write;
- the flag rises only after a divided tick or a bypass write;
- the interrupt never fires without the flag.

The exact length of the delay can only be shown by the bench's scenarios. These cover counts of 0, 5 and 255, a restart in the middle of a countdown, an aborted countdown with pulses that follow it, and the register readback values.

// File: rtl/osc_timer_pkg.sv
package osc_timer_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STATUS = 2'd1,
    REG_MASK   = 2'd2,
    REG_SPARE  = 2'd3
  } osc_reg_e;

  localparam int EN_BIT  = 0;
  localparam int BYP_BIT = 1;
  localparam int CNT_LSB = 8;

  typedef struct packed {
    logic       start;
    logic       stop;
    logic       bypass;
  } osc_cmd_t;
endpackage

// File: rtl/osc_prescaler.sv
module osc_prescaler #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ce,
  output logic tick
);
  localparam logic [DIV_LOG2-1:0] LAST = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= '0;
    else if (clr)    phase_q <= '0;
    else if (ce)     phase_q <= phase_q + 1'b1;
  end

  assign tick = ce && !clr && (phase_q == LAST);
endmodule

// File: rtl/osc_countdown.sv
module osc_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             force_set,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             stable,
  output logic             running
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      running  <= 1'b0;
      stable   <= 1'b0;
    end else if (start) begin
      remain_q <= load_val;
      running  <= 1'b1;
      stable   <= 1'b0;
    end else if (stop) begin
      running  <= 1'b0;
      stable   <= force_set;
    end else if (running && tick) begin
      if (remain_q <= ONE) begin
        remain_q <= '0;
        running  <= 1'b0;
        stable   <= 1'b1;
      end else begin
        remain_q <= remain_q - ONE;
      end
    end
  end
endmodule

// File: rtl/osc_regs.sv
module osc_regs
  import osc_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              stable,
  output logic [DATA_W-1:0] rd_data,
  output osc_cmd_t          cmd,
  output logic [CNT_W-1:0]  load_val,
  output logic              irq
);
  localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

  logic             en_q, byp_q, mask_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_wr, mask_wr;
  logic             unused_wdata;

  assign ctrl_wr = wr_en && (osc_reg_e'(wr_addr) == REG_CTRL);
  assign mask_wr = wr_en && (osc_reg_e'(wr_addr) == REG_MASK);

  assign cmd.start  = ctrl_wr && wr_data[EN_BIT];
  assign cmd.stop   = ctrl_wr && !wr_data[EN_BIT];
  assign cmd.bypass = wr_data[BYP_BIT];
  assign load_val   = wr_data[CNT_MSB:CNT_LSB];

  generate
    if (DATA_W > CNT_MSB + 1) begin : g_hi
      assign unused_wdata = ^{wr_data[DATA_W-1:CNT_MSB+1], wr_data[CNT_LSB-1:2]};
    end else begin : g_nohi
      assign unused_wdata = ^wr_data[CNT_LSB-1:2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      byp_q  <= 1'b0;
      cnt_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= wr_data[EN_BIT];
        byp_q <= wr_data[BYP_BIT];
        cnt_q <= wr_data[CNT_MSB:CNT_LSB];
      end
      if (mask_wr) mask_q <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (osc_reg_e'(rd_addr))
      REG_CTRL: begin
        rd_data[EN_BIT]          = en_q;
        rd_data[BYP_BIT]         = byp_q;
        rd_data[CNT_MSB:CNT_LSB] = cnt_q;
      end
      REG_STATUS: rd_data[0] = stable;
      REG_MASK:   rd_data[0] = mask_q;
      REG_SPARE:  rd_data    = '0;
      default:    rd_data    = '0;
    endcase
  end

  assign irq = stable && mask_q;
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
  import osc_timer_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 8,
  parameter int DIV_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_ce,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              osc_stable,
  output logic              irq
);
  osc_cmd_t         cmd;
  logic [CNT_W-1:0] load_val;
  logic             div_tick;
  logic             unused_running;

  osc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .stable(osc_stable),
    .rd_data(rd_data), .cmd(cmd), .load_val(load_val), .irq(irq)
  );

  osc_prescaler #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(cmd.start), .ce(slow_ce), .tick(div_tick)
  );

  osc_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(cmd.start), .stop(cmd.stop),
    .force_set(cmd.bypass), .load_val(load_val), .tick(div_tick),
    .stable(osc_stable), .running(unused_running)
  );
endmodule

// File: rtl/osc_startup_checker.sv
module osc_startup_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              div_tick,
  input logic              osc_stable,
  input logic              irq
);
  logic ctl_w;
  assign ctl_w = wr_en && (wr_addr == 2'd0);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && wr_data[0]) |=> !osc_stable); // R2
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !wr_data[0] && !wr_data[1]) |=> !osc_stable); // R6
  AST_BYPASS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !wr_data[0] && wr_data[1]) |=> osc_stable); // R7
  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stable && !ctl_w) |=> osc_stable); // R3
  AST_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_stable) |-> ($past(div_tick) || $past(ctl_w && wr_data[1]))); // R3
  AST_IRQ_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> osc_stable); // R9
endmodule

bind osc_startup_timer osc_startup_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .div_tick(div_tick), .osc_stable(osc_stable), .irq(irq)
);

// File: tb/sim_osc_startup_timer.sv
module sim_osc_startup_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        osc_stable, irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  osc_startup_timer u0 (
    .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .osc_stable(osc_stable), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_ce = 1'b1;
      @(negedge clk); slow_ce = 1'b0;
    end
  endtask

  function automatic logic [15:0] start_word(logic [7:0] n);
    return {n, 8'h01};
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 stable", {15'b0, osc_stable}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    rd(2'd0, d); chk("R1 ctrl", d, 16'h0);
    rd(2'd2, d); chk("R1 mask", d, 16'h0);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    wr(2'd0, start_word(8'd5));
    chk("R2 cleared", {15'b0, osc_stable}, 16'h0);
    pulses(39); chk("R3 early", {15'b0, osc_stable}, 16'h0);
    pulses(1);  chk("R3 on time", {15'b0, osc_stable}, 16'h1);
    pulses(20); chk("R3 holds", {15'b0, osc_stable}, 16'h1);
    rd(2'd1, d); chk("R10 status", d, 16'h1);
    rd(2'd0, d); chk("R10 ctrl", d, 16'h0501);
  endtask

  task automatic t_zero();
    wr(2'd0, start_word(8'd0));
    chk("R2 clear from set", {15'b0, osc_stable}, 16'h0);
    pulses(7); chk("R4 early", {15'b0, osc_stable}, 16'h0);
    pulses(1); chk("R4 on time", {15'b0, osc_stable}, 16'h1);
  endtask

  task automatic t_max();
    wr(2'd0, start_word(8'd255));
    pulses(2039); chk("R5 early", {15'b0, osc_stable}, 16'h0);
    pulses(1);    chk("R5 on time", {15'b0, osc_stable}, 16'h1);
  endtask

  task automatic t_reload();
    wr(2'd0, start_word(8'd4));
    pulses(20);
    wr(2'd0, start_word(8'd4));
    pulses(31); chk("R8 restart early", {15'b0, osc_stable}, 16'h0);
    pulses(1);  chk("R8 restart on time", {15'b0, osc_stable}, 16'h1);
  endtask

  task automatic t_disable();
    wr(2'd0, start_word(8'd3));
    pulses(10);
    wr(2'd0, 16'h0300);
    chk("R6 cleared", {15'b0, osc_stable}, 16'h0);
    pulses(30); chk("R6 stopped", {15'b0, osc_stable}, 16'h0);
    wr(2'd0, start_word(8'd0)); pulses(8);
    wr(2'd0, 16'h0000);
    chk("R6 clear from set", {15'b0, osc_stable}, 16'h0);
  endtask

  task automatic t_bypass();
    logic [15:0] d;
    wr(2'd0, 16'h0002);
    chk("R7 immediate", {15'b0, osc_stable}, 16'h1);
    rd(2'd0, d); chk("R10 bypass readback", d, 16'h0002);
  endtask

  task automatic t_both();
    wr(2'd0, 16'h0203);
    chk("R11 cleared", {15'b0, osc_stable}, 16'h0);
    pulses(15); chk("R11 early", {15'b0, osc_stable}, 16'h0);
    pulses(1);  chk("R11 on time", {15'b0, osc_stable}, 16'h1);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    chk("R9 masked", {15'b0, irq}, 16'h0);
    wr(2'd2, 16'h0001);
    chk("R9 raised", {15'b0, irq}, 16'h1);
    rd(2'd2, d); chk("R9 mask readback", d, 16'h1);
    wr(2'd0, 16'h0000);
    chk("R9 drops with flag", {15'b0, irq}, 16'h0);
    rd(2'd3, d); chk("R10 spare", d, 16'h0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero();
    t_max();
    t_reload();
    t_disable();
    t_bypass();
    t_both();
    t_irq();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end
endmodule